// File: doc/BRIEF.md
# Multiplexed-Address Single-Bit DRAM Emulator

This block is a synthesizable stand-in for a dynamic RAM that takes its row and column addresses on one shared bus, one after the other. It is meant to sit on the far side of a memory controller under test. All strobes are active low: `ras_n` is the row strobe, `cas_n` the column strobe and `we_n` the write strobe. The block samples them, with the address bus and the data input, on a fast system clock. It keeps the data in a small internal bit array, and it drives a read bit together with an output-enable. Only the low row and column address bits select a cell, so the array stays small. The upper address bits are accepted and have no effect.

The order in which the strobes fall decides each access. A row opens when the row strobe falls. A column access counts only once the row hold time has passed. The fall of the write strobe, taken relative to the column strobe, decides the access type:

- **Read:** the write strobe is high when the column strobe falls.
- **Early write:** the write strobe is already low when the column strobe falls. The data bit is taken at the column edge and the read bit is never enabled.
- **Late write / read-write:** the write strobe falls later, while the column strobe is low. The stored bit is shown first, and the new bit is written at the write edge.

Keeping the row strobe low while the column strobe toggles gives page-mode access along one row. A column strobe that falls while the row strobe is high starts a refresh-type cycle, which moves no data. A timing-error flag reports three kinds of violation: short row precharge, a short row-to-column delay, and a short column-high time between page accesses. The flag stays set until reset. Reset clears the control state but leaves the cell contents unchanged.

The signals are pin-level strobes, so there is no valid/ready handshake. Every input is taken as-is on each clock edge, and the block applies no back-pressure.

Top module: `dram_emu`

## Requirements
- R1: After reset, `dout_oe` is 0 and `timing_err` is 0.
- R2: The cell index is {row, col}. The row is the low ROW_BITS of `addr`, taken at the clock where `ras_n` is first seen low. The column is the low COL_BITS of `addr`, taken at each accepted `cas_n` fall. The upper address bits have no effect.
- R3: A `cas_n` fall seen fewer than T_RAH clocks after the `ras_n` fall is ignored for the whole time `cas_n` stays low. In that case `dout_oe` stays 0 and nothing is written.
- R4: `dout_oe` is 1 only while `cas_n` is low after an accepted read-type access. It drops at the clock after `cas_n` is seen high. While it is 1, `dout` equals the addressed stored bit.
- R5: If `we_n` is low at the accepted `cas_n` fall, the access is an early write. This includes `we_n` falling at the same clock as `cas_n`. `din` is stored at that clock and `dout_oe` stays 0.
- R6: If `we_n` falls while an accepted read is in progress, `dout` first shows the old bit. `din` is then stored at the `we_n` fall, and `dout` shows the new bit from the next clock.
- R7: While `ras_n` stays low, each new `cas_n` fall accesses a new column of the same row.
- R8: `timing_err` sets if `ras_n` falls fewer than T_RP clocks after it rose.
- R9: `timing_err` sets if the first `cas_n` fall of a row cycle comes fewer than T_RCD clocks after the `ras_n` fall. An access that meets T_RAH is still performed.
- R10: `timing_err` sets if a later `cas_n` fall within the same row cycle follows fewer than T_CP clocks of `cas_n` high.
- R11: If `cas_n` is already low when `ras_n` falls, the cycle is a refresh. No write occurs, even with `we_n` low, and `dout_oe` stays 0.
- R12: Once set, `timing_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Shared row/column address bus |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit (0 when not enabled) |
| dout_oe | output | 1 | Read data output enable |
| timing_err | output | 1 | Sticky timing-violation flag |

## Verification
Two things can fall on the same sampled clock. The first is the write strobe fall and the column strobe fall, which must be classed as an early write. The bench drives both strobes low on the same clock. It judges the result by `dout_oe` staying 0 and by a later read-back of the stored bit. The second is a column access and a row-to-column delay violation. The bench opens a column after the row hold time has passed but before the minimum delay. It then expects valid read data and `timing_err` set, both at the same sample.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;

  // kind of the column access in progress
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_EARLY = 2'd2,
    ACC_LATE  = 2'd3
  } acc_e;

endpackage

// File: rtl/dram_emu_pins.sv
module dram_emu_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic ras_fall,
  output logic ras_rise,
  output logic cas_fall,
  output logic cas_rise,
  output logic we_fall,
  output logic cas_hi_q
);

  logic ras_q;
  logic we_q;

  // previous samples, inactive (high) out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_hi_q <= 1'b1;
      we_q     <= 1'b1;
    end else begin
      ras_q    <= ras_n;
      cas_hi_q <= cas_n;
      we_q     <= we_n;
    end
  end

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_hi_q & ~cas_n;
  assign cas_rise = ~cas_hi_q & cas_n;
  assign we_fall  = we_q & ~we_n;

endmodule

// File: rtl/dram_emu_timing.sv
module dram_emu_timing #(
  parameter int T_RAH = 2,
  parameter int T_RCD = 4,
  parameter int T_RP  = 3,
  parameter int T_CP  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_fall,
  input  logic ras_rise,
  input  logic cas_fall,
  input  logic cas_rise,
  input  logic ras_low,
  input  logic row_live,
  output logic gate_open,
  output logic timing_err
);

  localparam int M1  = (T_RAH > T_RCD) ? T_RAH : T_RCD;
  localparam int M2  = (T_RP > T_CP) ? T_RP : T_CP;
  localparam int LIM = (M1 > M2) ? M1 : M2;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] LIM_L = CW'(LIM);
  localparam logic [CW-1:0] RAH_L = CW'(T_RAH);
  localparam logic [CW-1:0] RCD_L = CW'(T_RCD);
  localparam logic [CW-1:0] RP_L  = CW'(T_RP);
  localparam logic [CW-1:0] CP_L  = CW'(T_CP);

  logic [CW-1:0] rcd_cnt;   // clocks since row strobe fell
  logic [CW-1:0] rp_cnt;    // clocks since row strobe rose
  logic [CW-1:0] cp_cnt;    // clocks since column strobe rose
  logic          page_armed;
  logic          rp_bad, rcd_bad, cp_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcd_cnt    <= LIM_L;
      rp_cnt     <= LIM_L;
      cp_cnt     <= LIM_L;
      page_armed <= 1'b0;
      timing_err <= 1'b0;
    end else begin
      if (ras_fall)              rcd_cnt <= {{(CW-1){1'b0}}, 1'b1};
      else if (rcd_cnt != LIM_L) rcd_cnt <= rcd_cnt + 1'b1;

      if (ras_rise)              rp_cnt <= {{(CW-1){1'b0}}, 1'b1};
      else if (rp_cnt != LIM_L)  rp_cnt <= rp_cnt + 1'b1;

      if (cas_rise)              cp_cnt <= {{(CW-1){1'b0}}, 1'b1};
      else if (cp_cnt != LIM_L)  cp_cnt <= cp_cnt + 1'b1;

      if (ras_fall)                              page_armed <= 1'b0;
      else if (cas_fall && row_live && ras_low)  page_armed <= 1'b1;

      if (rp_bad || rcd_bad || cp_bad) timing_err <= 1'b1;
    end
  end

  assign rp_bad  = ras_fall && (rp_cnt < RP_L);
  assign rcd_bad = cas_fall && row_live && ras_low && !page_armed && (rcd_cnt < RCD_L);
  assign cp_bad  = cas_fall && row_live && ras_low && page_armed && (cp_cnt < CP_L);

  assign gate_open = (rcd_cnt >= RAH_L);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |=> timing_err); // R12

  AST_ERR_HAS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timing_err) |-> $past(ras_fall || cas_fall)); // R8

endmodule

// File: rtl/dram_emu_cells.sv
module dram_emu_cells #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);

  localparam int DEPTH = 1 << IDX_W;

  logic cells [DEPTH];

  // contents survive reset on purpose
  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[wr_idx] <= wr_bit;
      AST_WR_BIT_KNOWN: assert (!$isunknown(wr_bit)); // R5
    end
  end

  assign rd_bit = cells[rd_idx];

endmodule

// File: rtl/dram_emu.sv
module dram_emu
  import dram_emu_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  parameter int T_RAH    = 2,
  parameter int T_RCD    = 4,
  parameter int T_RP     = 3,
  parameter int T_CP     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic              timing_err
);

  localparam int IDX_W = ROW_BITS + COL_BITS;
  localparam int LOW_W = (ROW_BITS < COL_BITS) ? ROW_BITS : COL_BITS;

  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, cas_hi_q;
  logic ras_low, gate_open;
  logic row_open, refresh_cyc, row_live;
  logic cas_live;
  acc_e acc_q;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;
  logic accept, wr_early, wr_late, wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic rd_bit;
  logic unused_addr_hi;

  assign unused_addr_hi = ^addr[ADDR_W-1:LOW_W];

  dram_emu_pins u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ras_fall (ras_fall),
    .ras_rise (ras_rise),
    .cas_fall (cas_fall),
    .cas_rise (cas_rise),
    .we_fall  (we_fall),
    .cas_hi_q (cas_hi_q)
  );

  assign ras_low  = ~ras_n;
  assign row_live = row_open & ~refresh_cyc;

  dram_emu_timing #(
    .T_RAH (T_RAH),
    .T_RCD (T_RCD),
    .T_RP  (T_RP),
    .T_CP  (T_CP)
  ) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_fall   (ras_fall),
    .ras_rise   (ras_rise),
    .cas_fall   (cas_fall),
    .cas_rise   (cas_rise),
    .ras_low    (ras_low),
    .row_live   (row_live),
    .gate_open  (gate_open),
    .timing_err (timing_err)
  );

  // column edge counts only inside a data row and past the row hold time
  assign accept   = cas_fall & row_live & ras_low & gate_open;
  assign wr_early = accept & ~we_n;
  assign wr_late  = we_fall & cas_live & ~cas_n & ras_low & row_live
                  & (acc_q == ACC_READ);
  assign wr_en    = wr_early | wr_late;

  // row state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open    <= 1'b0;
      refresh_cyc <= 1'b0;
      row_q       <= '0;
    end else if (ras_fall) begin
      row_open    <= 1'b1;
      refresh_cyc <= ~cas_n;
      row_q       <= addr[ROW_BITS-1:0];
    end else if (ras_rise) begin
      row_open    <= 1'b0;
      refresh_cyc <= 1'b0;
    end
  end

  // column access state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_live <= 1'b0;
      acc_q    <= ACC_NONE;
      col_q    <= '0;
    end else if (accept) begin
      cas_live <= 1'b1;
      acc_q    <= we_n ? ACC_READ : ACC_EARLY;
      col_q    <= addr[COL_BITS-1:0];
    end else if (cas_rise) begin
      cas_live <= 1'b0;
      acc_q    <= ACC_NONE;
    end else if (wr_late) begin
      acc_q    <= ACC_LATE;
    end
  end

  assign wr_idx = wr_early ? {row_q, addr[COL_BITS-1:0]} : {row_q, col_q};
  assign rd_idx = {row_q, col_q};

  dram_emu_cells #(
    .IDX_W (IDX_W)
  ) u_cells (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_bit (din),
    .rd_idx (rd_idx),
    .rd_bit (rd_bit)
  );

  assign dout_oe = cas_live & ((acc_q == ACC_READ) | (acc_q == ACC_LATE));
  assign dout    = dout_oe & rd_bit;

  AST_Q_NEEDS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    cas_hi_q |-> !dout_oe); // R4

  AST_Q_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> $past(we_n)); // R5

  AST_ACCESS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_live) |-> $past(!ras_n)); // R3

  AST_ONE_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_early, wr_late})); // R6

  AST_REFRESH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_cyc |-> !wr_en); // R11

endmodule

// File: tb/dram_emu_tb.sv
module dram_emu_tb;

  localparam int AW  = 11;
  localparam int RB  = 4;
  localparam int CB  = 4;
  localparam int RAH = 2;
  localparam int RCD = 4;
  localparam int RP  = 3;
  localparam int CP  = 2;
  localparam int NR  = 1 << RB;
  localparam int NC  = 1 << CB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ras_n = 1'b1;
  logic          cas_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          din = 1'b0;
  logic          dout, dout_oe, timing_err;

  bit exp_mem [NR*NC];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dram_emu #(
    .ADDR_W (AW), .ROW_BITS (RB), .COL_BITS (CB),
    .T_RAH (RAH), .T_RCD (RCD), .T_RP (RP), .T_CP (CP)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .ras_n (ras_n), .cas_n (cas_n),
    .we_n (we_n), .addr (addr), .din (din),
    .dout (dout), .dout_oe (dout_oe), .timing_err (timing_err)
  );

  function automatic bit pat(int r, int c);
    return 1'((r * 5 + c * 3 + ((r * c) >> 2)) & 1);
  endfunction

  function automatic logic [AW-1:0] row_addr(int r);
    return AW'(r + ((r * 7 + 3) << RB));
  endfunction

  function automatic logic [AW-1:0] col_addr(int c);
    return AW'(c + ((c * 11 + 5) << CB));
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic open_row(int r, int gap);
    addr = row_addr(r); ras_n = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic close_row();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    repeat (RP) @(negedge clk);
  endtask

  task automatic cas_on(int c, bit w, bit d);
    addr = col_addr(c); we_n = w; din = d; cas_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic cas_off();
    cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    chk("R4 Q off after CAS high", int'(dout_oe), 0);
    @(negedge clk);
  endtask

  task automatic read_bit(int r, int c, string tag);
    open_row(r, RCD);
    cas_on(c, 1'b1, 1'b0);
    chk(tag, int'(dout), int'(exp_mem[r*NC+c]));
    cas_off();
    close_row();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit b;
    do_reset();
    chk("R1 oe after reset", int'(dout_oe), 0);
    chk("R1 err after reset", int'(timing_err), 0);

    // fill every cell with coincident W/CAS early writes, page mode per row
    for (int r = 0; r < NR; r++) begin
      open_row(r, RCD);
      for (int c = 0; c < NC; c++) begin
        b = pat(r, c);
        cas_on(c, 1'b0, b);
        chk("R5 early write keeps Q off", int'(dout_oe), 0);
        exp_mem[r*NC+c] = b;
        cas_off();
      end
      close_row();
    end
    chk("R10 no error on legal page timing", int'(timing_err), 0);

    // read back every cell in page mode
    for (int r = 0; r < NR; r++) begin
      open_row(r, RCD);
      for (int c = 0; c < NC; c++) begin
        cas_on(c, 1'b1, 1'b0);
        chk("R7 page read data", int'(dout), int'(exp_mem[r*NC+c]));
        chk("R4 Q on during read", int'(dout_oe), 1);
        cas_off();
      end
      close_row();
    end
    chk("R2 no error after read sweep", int'(timing_err), 0);

    // W low one clock before CAS: early write
    b = ~exp_mem[4*NC+9];
    open_row(4, RCD);
    we_n = 1'b0; din = b;
    @(negedge clk);
    cas_on(9, 1'b0, b);
    chk("R5 W-before-CAS Q off", int'(dout_oe), 0);
    cas_off();
    close_row();
    exp_mem[4*NC+9] = b;
    read_bit(4, 9, "R5 early write stored");

    // read-write: old bit, then new bit after the W edge
    b = ~exp_mem[5*NC+7];
    open_row(5, RCD);
    cas_on(7, 1'b1, 1'b0);
    chk("R6 old bit before W", int'(dout), int'(exp_mem[5*NC+7]));
    we_n = 1'b0; din = b;
    @(negedge clk);
    chk("R6 new bit after W", int'(dout), int'(b));
    chk("R6 Q still on", int'(dout_oe), 1);
    cas_off();
    close_row();
    exp_mem[5*NC+7] = b;
    read_bit(5, 7, "R6 late write stored");
    read_bit(5, 6, "R2 neighbour untouched");

    // CAS before row hold: ignored, and a delay error
    b = ~exp_mem[9*NC+2];
    open_row(9, 1);
    cas_on(2, 1'b0, b);
    chk("R3 early CAS no Q", int'(dout_oe), 0);
    repeat (3) @(negedge clk);
    chk("R3 held CAS still no Q", int'(dout_oe), 0);
    chk("R9 short RAS-CAS flagged", int'(timing_err), 1);
    cas_off();
    close_row();
    repeat (5) @(negedge clk);
    chk("R12 flag stays set", int'(timing_err), 1);
    do_reset();
    chk("R12 reset clears flag", int'(timing_err), 0);
    read_bit(9, 2, "R3 ignored write left cell");

    // past row hold but under tRCD: access happens and flag sets
    open_row(3, RCD - 1);
    cas_on(4, 1'b1, 1'b0);
    chk("R9 access still done", int'(dout), int'(exp_mem[3*NC+4]));
    chk("R9 flag with access", int'(timing_err), 1);
    cas_off();
    close_row();
    do_reset();

    // short precharge
    open_row(1, RCD);
    cas_on(0, 1'b1, 1'b0);
    cas_off();
    ras_n = 1'b1;
    @(negedge clk);
    chk("R8 no error before", int'(timing_err), 0);
    ras_n = 1'b0;
    @(negedge clk);
    chk("R8 short precharge flagged", int'(timing_err), 1);
    ras_n = 1'b1;
    @(negedge clk);
    do_reset();

    // short CAS high in page mode
    open_row(2, RCD);
    cas_on(0, 1'b1, 1'b0);
    cas_n = 1'b1;
    @(negedge clk);
    cas_on(1, 1'b1, 1'b0);
    chk("R10 short CAS high flagged", int'(timing_err), 1);
    chk("R7 page column still read", int'(dout), int'(exp_mem[2*NC+1]));
    cas_off();
    close_row();
    do_reset();

    // CAS before RAS: refresh, no transfer
    b = ~exp_mem[6*NC+0];
    addr = col_addr(0);
    cas_n = 1'b0;
    @(negedge clk);
    addr = row_addr(6); ras_n = 1'b0; we_n = 1'b0; din = b;
    repeat (4) @(negedge clk);
    chk("R11 refresh Q off", int'(dout_oe), 0);
    ras_n = 1'b1;
    @(negedge clk);
    cas_n = 1'b1; we_n = 1'b1;
    repeat (RP) @(negedge clk);
    chk("R11 refresh no error", int'(timing_err), 0);
    read_bit(6, 0, "R11 refresh wrote nothing");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule